// File: doc/BRIEF.md
# Two-Channel DMA Controller

This block moves data between two memory-mapped locations on a simple single-master bus, on behalf of two independent channels. Each channel holds a source address, a destination address, a 16-bit unit count and a control word. A channel becomes ready to move data either when software sets its go bit or when a hardware request line is high. The line comes from a shared set of request inputs, and each channel picks one of them through a select field. Every unit is moved as one bus read followed by one bus write. Its width is 8, 16 or 32 bits, carried right-aligned on the data lines.

An arbiter decides which ready channel gets the bus. It works in either fixed-priority or round-robin mode, set by one global bit. A channel in cycle-steal operation gives up the bus after each unit and must win arbitration again. A channel in burst operation keeps the bus until its count runs out. When the count runs out, the channel turns itself off and sets a done flag. The flag drives that channel's interrupt line unless it is masked, and software clears it by writing 1. A request line that started a transfer gets a one-cycle acknowledge pulse when that transfer ends.

The sequencer is a four-state machine:
- IDLE goes to READ when the arbiter grants a channel.
- READ stays put until `bus_ready`, then goes to WRITE.
- WRITE stays put until `bus_ready`. It then goes back to READ when the channel is in burst operation with units left, and to RELEASE otherwise.
- RELEASE always returns to IDLE after one cycle.

Top module: `dma2ch`

## Requirements
- R1: After reset, `bus_cyc`, `hw_ack` and `irq` are 0, and every register reads as zero.
- R2: `reg_addr` is a word index. Index 0 to 3 select channel 0 and 4 to 7 select channel 1, in the order source, destination, count, control. Index 8 is the global register, whose bit 0 selects round-robin (1) or fixed (0). The control word has these fields:
  - bit 0: enable
  - bit 1: go
  - bit 2: hardware trigger
  - bit 3: burst
  - bits 5:4: size (0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit)
  - bit 6: source increment
  - bit 7: destination increment
  - bit 8: interrupt enable
  - bits 11:9: request-line select
  - bit 16: done
- R3: Each unit is one read of the source address followed by one write of the destination address. Read data is masked to the unit size, and a write changes only the bytes of that size.
- R4: An incrementing address advances by the unit size in bytes (1, 2 or 4) after each unit. A fixed address does not change.
- R5: The count decreases by one per unit, and the channel stops when it reaches zero. A written count of 0 stands for 65,536 units, so after one unit it reads 0xFFFF and the channel is still enabled.
- R6: When the count runs out, the enable bit clears and done sets. `irq` for that channel is high when done and interrupt enable are both 1. Writing 1 to bit 16 clears done.
- R7: In software mode, writing enable and go together makes the channel move its whole count without further requests.
- R8: In hardware mode, only the request line chosen by the select field starts transfers. Other lines have no effect.
- R9: A hardware-started transfer raises `hw_ack` on the selected line for exactly one cycle while the bus is idle. In cycle-steal operation this happens after each unit, and in burst operation after the last unit.
- R10: In cycle-steal operation, `bus_cyc` drops between units.
- R11: In burst operation, `bus_cyc` stays high from the first unit to the last.
- R12: In fixed mode, channel 0 wins whenever both channels are ready.
- R13: In round-robin mode, when both channels are ready, the channel not granted last wins.
- R14: While `bus_ready` is low, `bus_cyc`, `bus_we`, `bus_addr` and `bus_size` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_cyc | output | 1 | Bus access in progress |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Byte address |
| bus_size | output | 2 | 0 = byte, 1 = halfword, 2 = word |
| bus_wdata | output | 32 | Write data, right-aligned |
| bus_rdata | input | 32 | Read data, right-aligned |
| bus_ready | input | 1 | Access completes on this cycle |
| hw_req | input | NHW | Hardware request lines |
| hw_ack | output | NHW | One-cycle acknowledge per line |
| irq | output | 2 | Per-channel interrupt |

## Verification
A sequencer stuck in READ or WRITE shows up at once: `bus_cyc` stays high with a frozen address, and done never sets. A wrong owner or a corrupted arbiter history shows up within one arbitration as a wrong interleaving of source addresses on the bus. A wrong address step or data mask is caught when the copied region is compared, byte by byte, against its guard bytes after the transfer ends. Count errors show up as a done flag that arrives early, late or never, and as a wrong count read back after a single unit.

// File: rtl/dma2ch_pkg.sv
package dma2ch_pkg;
    localparam int NCH   = 2;
    localparam int DW    = 32;
    localparam int CNT_W = 16;
    localparam int SEL_W = 3;

    // control word bit positions
    localparam int B_EN    = 0;
    localparam int B_GO    = 1;
    localparam int B_HW    = 2;
    localparam int B_BURST = 3;
    localparam int B_SZ    = 4;
    localparam int B_SINC  = 6;
    localparam int B_DINC  = 7;
    localparam int B_IE    = 8;
    localparam int B_SEL   = 9;
    localparam int B_DONE  = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_RELEASE
    } eng_state_t;

    function automatic logic [DW-1:0] lane_mask(input logic [1:0] sz);
        unique case (sz)
            2'd0:    lane_mask = 32'h0000_00FF;
            2'd1:    lane_mask = 32'h0000_FFFF;
            default: lane_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
        unique case (sz)
            2'd0:    unit_bytes = 3'd1;
            2'd1:    unit_bytes = 3'd2;
            default: unit_bytes = 3'd4;
        endcase
    endfunction

    function automatic logic [1:0] bus_code(input logic [1:0] sz);
        bus_code = (sz == 2'd3) ? 2'd2 : sz;
    endfunction
endpackage

// File: rtl/dma2ch_chan.sv
module dma2ch_chan
    import dma2ch_pkg::*;
#(
    parameter int AW  = 32,
    parameter int NHW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [1:0]       rd_idx,
    input  logic             adv,
    input  logic [NHW-1:0]   hw_req,
    output logic [AW-1:0]    src_o,
    output logic [AW-1:0]    dst_o,
    output logic [1:0]       size_o,
    output logic             burst_o,
    output logic             hwtrig_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             req_o,
    output logic             last_o,
    output logic             irq_o,
    output logic [DW-1:0]    rd_data
);
    localparam int HSW = (NHW > 1) ? $clog2(NHW) : 1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [AW-1:0]    src, dst;
    logic [CNT_W-1:0] cnt;
    logic             en, go, hwtrig, burst, sinc, dinc, ie, done;
    logic [1:0]       size;
    logic [SEL_W-1:0] sel;
    logic [AW-1:0]    step;

    assign step = {{(AW-3){1'b0}}, unit_bytes(size)};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src <= '0; dst <= '0; cnt <= '0;
            en <= 1'b0; go <= 1'b0; hwtrig <= 1'b0; burst <= 1'b0;
            sinc <= 1'b0; dinc <= 1'b0; ie <= 1'b0; size <= '0; sel <= '0;
            done <= 1'b0;
        end else begin
            if (wr_en) begin
                unique case (wr_idx)
                    2'd0: src <= wr_data[AW-1:0];
                    2'd1: dst <= wr_data[AW-1:0];
                    2'd2: cnt <= wr_data[CNT_W-1:0];
                    2'd3: begin
                        en     <= wr_data[B_EN];
                        go     <= wr_data[B_EN] & (wr_data[B_GO] | go);
                        hwtrig <= wr_data[B_HW];
                        burst  <= wr_data[B_BURST];
                        size   <= wr_data[B_SZ +: 2];
                        sinc   <= wr_data[B_SINC];
                        dinc   <= wr_data[B_DINC];
                        ie     <= wr_data[B_IE];
                        sel    <= wr_data[B_SEL +: SEL_W];
                        if (wr_data[B_DONE]) done <= 1'b0;
                    end
                endcase
            end
            // engine advance wins over a same-cycle register write
            if (adv) begin
                if (sinc) src <= src + step;
                if (dinc) dst <= dst + step;
                cnt <= cnt - CNT_ONE;
                if (cnt == CNT_ONE) begin
                    en   <= 1'b0;
                    go   <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign src_o    = src;
    assign dst_o    = dst;
    assign size_o   = size;
    assign burst_o  = burst;
    assign hwtrig_o = hwtrig;
    assign sel_o    = sel;
    assign last_o   = (cnt == CNT_ONE);
    assign irq_o    = done & ie;
    assign req_o    = en & (hwtrig ? hw_req[sel[HSW-1:0]] : go);

    always_comb begin
        rd_data = '0;
        unique case (rd_idx)
            2'd0: rd_data[AW-1:0]    = src;
            2'd1: rd_data[AW-1:0]    = dst;
            2'd2: rd_data[CNT_W-1:0] = cnt;
            2'd3: begin
                rd_data[B_EN]           = en;
                rd_data[B_GO]           = go;
                rd_data[B_HW]           = hwtrig;
                rd_data[B_BURST]        = burst;
                rd_data[B_SZ +: 2]      = size;
                rd_data[B_SINC]         = sinc;
                rd_data[B_DINC]         = dinc;
                rd_data[B_IE]           = ie;
                rd_data[B_SEL +: SEL_W] = sel;
                rd_data[B_DONE]         = done;
            end
        endcase
    end
endmodule

// File: rtl/dma2ch_arb.sv
module dma2ch_arb
    import dma2ch_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rr_mode,
    input  logic [NCH-1:0] req,
    input  logic           take,
    output logic [NCH-1:0] gnt
);
    logic last_ch;  // channel granted most recently

    always_comb begin
        if (req == 2'b11) begin
            if (rr_mode && !last_ch) gnt = 2'b10;
            else                     gnt = 2'b01;
        end else begin
            gnt = req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    last_ch <= 1'b1;
        else if (take) last_ch <= gnt[1];
    end
endmodule

// File: rtl/dma2ch_engine.sv
module dma2ch_engine
    import dma2ch_pkg::*;
#(
    parameter int AW  = 32,
    parameter int NHW = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NCH-1:0]                gnt,
    input  logic [NCH-1:0][AW-1:0]        src,
    input  logic [NCH-1:0][AW-1:0]        dst,
    input  logic [NCH-1:0][1:0]           size,
    input  logic [NCH-1:0]                burst,
    input  logic [NCH-1:0]                hwtrig,
    input  logic [NCH-1:0][SEL_W-1:0]     sel,
    input  logic [NCH-1:0]                last,
    output logic                          take,
    output logic [NCH-1:0]                adv,
    output logic                          bus_cyc,
    output logic                          bus_we,
    output logic [AW-1:0]                 bus_addr,
    output logic [1:0]                    bus_size,
    output logic [DW-1:0]                 bus_wdata,
    input  logic [DW-1:0]                 bus_rdata,
    input  logic                          bus_ready,
    output logic [NHW-1:0]                hw_ack
);
    localparam int HSW = (NHW > 1) ? $clog2(NHW) : 1;

    eng_state_t    st, st_nx;
    logic          own;
    logic [DW-1:0] data;

    // state register, owner and data holding
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            own  <= 1'b0;
            data <= '0;
        end else begin
            st <= st_nx;
            if (st == ST_IDLE && |gnt)
                own <= gnt[1];
            if (st == ST_READ && bus_ready)
                data <= bus_rdata & lane_mask(size[own]);
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:    if (|gnt) st_nx = ST_READ;
            ST_READ:    if (bus_ready) st_nx = ST_WRITE;
            ST_WRITE:   if (bus_ready)
                            st_nx = (burst[own] && !last[own]) ? ST_READ : ST_RELEASE;
            ST_RELEASE: st_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        take      = 1'b0;
        adv       = '0;
        bus_cyc   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_size  = bus_code(size[own]);
        bus_wdata = data;
        hw_ack    = '0;
        unique case (st)
            ST_IDLE:  take = |gnt;
            ST_READ: begin
                bus_cyc  = 1'b1;
                bus_addr = src[own];
            end
            ST_WRITE: begin
                bus_cyc  = 1'b1;
                bus_we   = 1'b1;
                bus_addr = dst[own];
                adv[own] = bus_ready;
            end
            ST_RELEASE:
                if (hwtrig[own]) hw_ack[sel[own][HSW-1:0]] = 1'b1;
        endcase
    end
endmodule

// File: rtl/dma2ch.sv
module dma2ch
    import dma2ch_pkg::*;
#(
    parameter int AW  = 32,
    parameter int NHW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic [3:0]     reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    output logic           bus_cyc,
    output logic           bus_we,
    output logic [AW-1:0]  bus_addr,
    output logic [1:0]     bus_size,
    output logic [31:0]    bus_wdata,
    input  logic [31:0]    bus_rdata,
    input  logic           bus_ready,
    input  logic [NHW-1:0] hw_req,
    output logic [NHW-1:0] hw_ack,
    output logic [1:0]     irq
);
    logic                      rr_mode;
    logic [NCH-1:0]            req_v, gnt_v, adv_v, last_v, burst_v, hw_v;
    logic [NCH-1:0][AW-1:0]    src_v, dst_v;
    logic [NCH-1:0][1:0]       size_v;
    logic [NCH-1:0][SEL_W-1:0] sel_v;
    logic [NCH-1:0][DW-1:0]    rd_v;
    logic                      take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     rr_mode <= 1'b0;
        else if (reg_wr && reg_addr[3]) rr_mode <= reg_wdata[0];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dma2ch_chan #(.AW(AW), .NHW(NHW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (reg_wr && !reg_addr[3] && (reg_addr[2] == 1'(c))),
            .wr_idx   (reg_addr[1:0]),
            .wr_data  (reg_wdata),
            .rd_idx   (reg_addr[1:0]),
            .adv      (adv_v[c]),
            .hw_req   (hw_req),
            .src_o    (src_v[c]),
            .dst_o    (dst_v[c]),
            .size_o   (size_v[c]),
            .burst_o  (burst_v[c]),
            .hwtrig_o (hw_v[c]),
            .sel_o    (sel_v[c]),
            .req_o    (req_v[c]),
            .last_o   (last_v[c]),
            .irq_o    (irq[c]),
            .rd_data  (rd_v[c])
        );
    end

    assign reg_rdata = reg_addr[3] ? {31'b0, rr_mode} : rd_v[reg_addr[2]];

    dma2ch_arb u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .rr_mode (rr_mode),
        .req     (req_v),
        .take    (take),
        .gnt     (gnt_v)
    );

    dma2ch_engine #(.AW(AW), .NHW(NHW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .gnt       (gnt_v),
        .src       (src_v),
        .dst       (dst_v),
        .size      (size_v),
        .burst     (burst_v),
        .hwtrig    (hw_v),
        .sel       (sel_v),
        .last      (last_v),
        .take      (take),
        .adv       (adv_v),
        .bus_cyc   (bus_cyc),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .hw_ack    (hw_ack)
    );
endmodule

// File: rtl/dma2ch_chk.sv
module dma2ch_chk #(
    parameter int AW  = 32,
    parameter int NHW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_cyc,
    input logic           bus_we,
    input logic           bus_ready,
    input logic [AW-1:0]  bus_addr,
    input logic [1:0]     bus_size,
    input logic [NHW-1:0] hw_ack,
    input logic [1:0]     req_v,
    input logic [1:0]     gnt_v,
    input logic           rr_mode
);
    p_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc && !bus_ready |=> bus_cyc && $stable(bus_we) && $stable(bus_addr) && $stable(bus_size));

    p_read_then_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc && !bus_we && bus_ready |=> bus_cyc && bus_we);

    p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        |hw_ack |=> hw_ack == '0);

    p_ack_onehot_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        |hw_ack |-> $onehot0(hw_ack) && !bus_cyc);

    p_gnt_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_v) && ((gnt_v & ~req_v) == 2'b00));

    p_fixed_prio_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rr_mode && req_v[0] |-> !gnt_v[1]);
endmodule

bind dma2ch dma2ch_chk #(.AW(AW), .NHW(NHW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_cyc   (bus_cyc),
    .bus_we    (bus_we),
    .bus_ready (bus_ready),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .hw_ack    (hw_ack),
    .req_v     (req_v),
    .gnt_v     (gnt_v),
    .rr_mode   (rr_mode)
);

// File: tb/sim_dma2ch.sv
`timescale 1ns/1ps
module sim_dma2ch;
    localparam int AW  = 32;
    localparam int NHW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic           reg_wr = 1'b0;
    logic [3:0]     reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    wire  [31:0]    reg_rdata;
    wire            bus_cyc, bus_we;
    wire  [AW-1:0]  bus_addr;
    wire  [1:0]     bus_size;
    wire  [31:0]    bus_wdata;
    logic [31:0]    bus_rdata;
    logic           bus_ready;
    logic [NHW-1:0] hw_req = '0;
    wire  [NHW-1:0] hw_ack;
    wire  [1:0]     irq;

    logic stall = 1'b0;
    logic tgl = 1'b0;
    logic [7:0] mem [0:1023];
    wire  [9:0] ba = bus_addr[9:0];

    dma2ch u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_cyc(bus_cyc),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .hw_req(hw_req), .hw_ack(hw_ack), .irq(irq)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) ^ (a >> 8));
    endfunction

    function automatic logic [31:0] pword(input int a);
        return {pat(a + 3), pat(a + 2), pat(a + 1), pat(a)};
    endfunction

    assign bus_ready = !stall || tgl;
    assign bus_rdata = {mem[ba + 10'd3], mem[ba + 10'd2], mem[ba + 10'd1], mem[ba]};

    // memory model: preloaded during reset, byte-lane writes
    always @(posedge clk) begin
        tgl <= ~tgl;
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mem[i] <= pat(i);
        end else if (bus_cyc && bus_we && bus_ready) begin
            mem[ba] <= bus_wdata[7:0];
            if (bus_size != 2'd0) mem[ba + 10'd1] <= bus_wdata[15:8];
            if (bus_size == 2'd2) begin
                mem[ba + 10'd2] <= bus_wdata[23:16];
                mem[ba + 10'd3] <= bus_wdata[31:24];
            end
        end
    end

    // bus monitor
    logic prev_cyc = 1'b0;
    int   rises = 0;
    int   acks = 0;
    int   nlog = 0;
    logic rdlog [0:63];
    always @(posedge clk) begin
        if (rst_n) begin
            prev_cyc <= bus_cyc;
            if (bus_cyc && !prev_cyc) rises <= rises + 1;
            if (|hw_ack) acks <= acks + 1;
            if (bus_cyc && !bus_we && bus_ready) begin
                rdlog[nlog % 64] <= bus_addr[6];
                nlog <= nlog + 1;
            end
        end
    end

    int total = 0;
    int fails = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_done(input int ch);
        logic [31:0] d;
        for (int i = 0; i < 3000; i++) begin
            rd(4'(ch * 4 + 3), d);
            if (d[16]) break;
        end
    endtask

    task automatic setup(input int ch, input int s, input int d, input int n, input logic [31:0] ctl);
        wr(4'(ch * 4 + 0), 32'(s));
        wr(4'(ch * 4 + 1), 32'(d));
        wr(4'(ch * 4 + 2), 32'(n));
        wr(4'(ch * 4 + 3), ctl);
    endtask

    task automatic hw_shake(input int line, output logic [NHW-1:0] seen);
        seen = '0;
        @(negedge clk);
        hw_req[line] = 1'b1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (hw_ack[line]) begin
                seen = hw_ack;
                break;
            end
        end
        hw_req[line] = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 bus_cyc", 32'(bus_cyc), 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 hw_ack", 32'(hw_ack), 0);
        for (int i = 0; i < 9; i++) begin
            rd(4'(i), d);
            check("R1 R2 register reset", d, 0);
        end
    endtask

    task automatic t_burst_word();
        logic [31:0] d;
        int r0;
        r0 = rises;
        setup(0, 'h100, 'h200, 4, 32'h1EB);
        wait_done(0);
        for (int k = 0; k < 4; k++)
            check("R3 R7 word copy", {mem['h203 + 4*k], mem['h202 + 4*k], mem['h201 + 4*k], mem['h200 + 4*k]},
                  pword('h100 + 4*k));
        rd(0, d); check("R4 src stepped by 4", d, 'h110);
        rd(1, d); check("R4 dst stepped by 4", d, 'h210);
        rd(2, d); check("R5 count exhausted", d, 0);
        rd(3, d); check("R6 enable cleared", 32'(d[0]), 0);
        check("R6 irq raised", 32'(irq[0]), 1);
        check("R11 burst holds bus", 32'(rises - r0), 1);
        wr(3, 32'h0001_0000);
        rd(3, d); check("R6 done cleared by write-1", 32'(d[16]), 0);
        check("R6 irq dropped", 32'(irq[0]), 0);
    endtask

    task automatic t_byte_steal();
        logic [31:0] d;
        int r0;
        r0 = rises;
        setup(1, 'h120, 'h300, 3, 32'h083);
        wait_done(1);
        for (int k = 0; k < 3; k++)
            check("R3 R4 byte from fixed source", 32'(mem['h300 + k]), 32'(pat('h120)));
        check("R3 byte write leaves neighbour", 32'(mem['h303]), 32'(pat('h303)));
        rd(4, d); check("R4 fixed src unchanged", d, 'h120);
        rd(5, d); check("R4 dst stepped by 1", d, 'h303);
        check("R10 cycle steal releases bus", 32'(rises - r0), 3);
        rd(7, d); check("R6 done set", 32'(d[16]), 1);
        check("R6 masked irq stays low", 32'(irq[1]), 0);
        wr(7, 32'h0001_0000);
    endtask

    task automatic t_half_stall();
        logic [31:0] d;
        stall = 1'b1;
        setup(0, 'h140, 'h340, 2, 32'h0DB);
        wait_done(0);
        stall = 1'b0;
        for (int k = 0; k < 4; k++)
            check("R14 R3 halfword copy under wait states", 32'(mem['h340 + k]), 32'(pat('h140 + k)));
        check("R3 halfword guard byte", 32'(mem['h344]), 32'(pat('h344)));
        rd(1, d); check("R4 dst stepped by 2", d, 'h344);
        wr(3, 32'h0001_0000);
    endtask

    task automatic t_hw_steal();
        logic [31:0] d;
        logic [NHW-1:0] seen;
        int r0, a0;
        setup(1, 'h160, 'h360, 2, 32'hAE5);
        r0 = rises;
        @(negedge clk); hw_req[2] = 1'b1;
        repeat (20) @(negedge clk);
        hw_req[2] = 1'b0;
        rd(6, d); check("R8 unselected line ignored (count)", d, 2);
        check("R8 unselected line ignored (bus)", 32'(rises - r0), 0);
        a0 = acks;
        hw_shake(5, seen);
        check("R9 ack on selected line only", 32'(seen), 32'h20);
        repeat (3) @(negedge clk);
        check("R9 ack is one cycle", 32'(acks - a0), 1);
        rd(6, d); check("R9 one unit per request", d, 1);
        hw_shake(5, seen);
        wait_done(1);
        check("R9 second ack", 32'(acks - a0), 2);
        check("R8 copy done", {mem['h367], mem['h366], mem['h365], mem['h364]}, pword('h164));
        wr(7, 32'h0001_0000);
    endtask

    task automatic t_hw_burst();
        logic [31:0] d;
        logic [NHW-1:0] seen;
        int r0, a0;
        setup(0, 'h170, 'h370, 3, 32'h0CD);
        r0 = rises; a0 = acks;
        hw_shake(0, seen);
        repeat (3) @(negedge clk);
        check("R9 burst ack at end only", 32'(acks - a0), 1);
        check("R11 hw burst single bus hold", 32'(rises - r0), 1);
        rd(2, d); check("R9 burst count exhausted", d, 0);
        check("R3 hw burst last byte", 32'(mem['h372]), 32'(pat('h172)));
        wr(3, 32'h0001_0000);
    endtask

    task automatic t_cnt0();
        logic [31:0] d;
        logic [NHW-1:0] seen;
        setup(1, 'h1A0, 'h3A0, 0, 32'h2E5);
        hw_shake(1, seen);
        repeat (2) @(negedge clk);
        rd(6, d); check("R5 zero count means 65536", d, 32'hFFFF);
        rd(7, d);
        check("R5 still enabled", 32'(d[0]), 1);
        check("R5 not done", 32'(d[16]), 0);
        wr(7, 32'h0);
    endtask

    task automatic t_prio(input logic rr, input int so, input string tag,
                          input logic e0, input logic e1, input logic e2, input logic e3);
        int n0;
        wr(8, 32'(rr));
        setup(0, 'h180 + so, 'h380 + so, 2, 32'h6E5);
        setup(1, 'h1C0 + so, 'h3C0 + so, 2, 32'h8E5);
        n0 = nlog;
        @(negedge clk);
        hw_req[3] = 1'b1; hw_req[4] = 1'b1;
        wait_done(1);
        wait_done(0);
        hw_req[3] = 1'b0; hw_req[4] = 1'b0;
        check(tag, 32'({rdlog[n0 % 64], rdlog[(n0+1) % 64], rdlog[(n0+2) % 64], rdlog[(n0+3) % 64]}),
              32'({e0, e1, e2, e3}));
        wr(3, 32'h0001_0000);
        wr(7, 32'h0001_0000);
    endtask

    task automatic run_all();
        t_reset();
        t_burst_word();
        t_byte_steal();
        t_half_stall();
        t_hw_steal();
        t_hw_burst();
        t_cnt0();
        t_prio(1'b0, 0, "R12 fixed order", 1'b0, 1'b0, 1'b1, 1'b1);
        t_prio(1'b1, 8, "R13 round-robin order", 1'b0, 1'b1, 1'b0, 1'b1);
    endtask

    initial begin
        logic timeout;
        timeout = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        disable fork;
        if (timeout) begin
            total++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule